// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End

This block is the bit-level slave side of a two-wire serial bus (I2C style) that sits in front of a byte-addressed memory. It oversamples the bus clock and data lines with the system clock. It resynchronises both lines and suppresses short glitches on them. From the cleaned lines it recognises START and STOP conditions, shifts in the device-select byte and compares it with a fixed prefix and three strap pins. It acknowledges on the ninth clock and shifts read data out MSB first. Data leaves the block only as an open-drain pull-down enable. The block never drives a high level.

Toward the memory logic the block offers a byte-level view. START and STOP arrive as single-cycle strobes, and so does a select hit, which comes with the direction bit. Received bytes leave on a valid/ready handshake. The ready signal is sampled only in the one cycle that valid is high. Ready high in that cycle means the byte is taken and acknowledged. Ready low means the byte is refused: it is answered with NACK and the slave drops off the bus until the next START. No stall is possible, because the bus clock is never stretched.

Read data is pulled on a second handshake. The block raises its ready for one cycle per byte. The memory side must present valid and data in that cycle, and an absent byte is sent as all ones. The master's acknowledge bit after each read byte is reported as a strobe. A busy input from the write engine makes the block ignore its own select byte, so a master can poll for the end of an internal write by watching for the acknowledge.

Top module: `tws_slave_front`

## Requirements
- R1: A falling SDA while SCL is high (after filtering) produces one `start_o` pulse. From any state it re-arms select-byte decoding.
- R2: A rising SDA while SCL is high produces one `stop_o` pulse, releases `sda_oe_o` and returns the slave to idle.
- R3: The first byte after START is compared bit for bit. Bits 7..4 must be 1010, and bits 3, 2 and 1 must equal `strap_i[2]`, `strap_i[1]` and `strap_i[0]`. Bit 0 is the direction, where 1 means read. On a hit the block pulses `match_o`, sets `rw_o` to bit 0 and pulls SDA low for the ninth clock. On a miss it gives no acknowledge and no further strobes until the next START.
- R4: While `busy_i` is high at the moment the select byte completes, the block neither pulses `match_o` nor acknowledges.
- R5: In write mode each completed byte is offered MSB-first on `rx_data_o` with a one-cycle `rx_valid_o`. If `rx_ready_i` is high in that cycle the byte is acknowledged. Otherwise the byte gets NACK and later bytes are ignored until START.
- R6: In read mode `tx_ready_o` is high for one cycle before each byte. The byte is sent MSB first, and a 0 bit is sent as `sda_oe_o`=1. If `tx_valid_i` is low in that cycle the byte is sent as 8'hFF.
- R7: After each read byte, the SDA level at the ninth SCL rise is reported on `mack_nack_o`, which is 1 for NACK, with a `mack_valid_o` pulse. After NACK the slave stays released until START or STOP. After ACK the next byte follows.
- R8: A repeated START in the middle of a byte abandons that byte and starts a fresh select-byte decode.
- R9: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks has no effect on any output.
- R10: After reset `sda_oe_o` is 0 and no strobe fires. `sda_oe_o` is high only in an acknowledge slot or a read data 0 bit, and at most one of the strobes fires in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull SDA low when 1; released when 0 |
| strap_i | input | 3 | Board strap bits matched against select bits 3..1 |
| busy_i | input | 1 | Internal write cycle in progress; suppresses select acknowledge |
| start_o | output | 1 | One-cycle START strobe |
| stop_o | output | 1 | One-cycle STOP strobe |
| match_o | output | 1 | One-cycle select hit strobe |
| rw_o | output | 1 | Direction of the last hit, 1 = read |
| rx_valid_o | output | 1 | Received byte offered this cycle |
| rx_ready_i | input | 1 | Memory side accepts the offered byte |
| rx_data_o | output | 8 | Received byte |
| tx_valid_i | input | 1 | Memory side has a byte to send |
| tx_ready_o | output | 1 | Block samples tx_valid_i and tx_data_i this cycle |
| tx_data_i | input | 8 | Byte to send |
| mack_valid_o | output | 1 | Master acknowledge bit sampled |
| mack_nack_o | output | 1 | 1 when the master answered NACK |

## Verification
The bench builds the block with `FILT_LEN` = 3 and a bus half-period of 12 system clocks. A 2-clock pulse on either line then sits one clock below the filter threshold. The slave's turnaround of roughly seven clocks after a bus clock fall lands well inside the low phase. The straps are tied to 101, so select bytes 8'hAA and 8'hAB hit and 8'hA2 misses. A model in the bench predicts every strobe in order, every acknowledge level and every read bit, and it flags any pull-down that lasts past a slot where the slave may drive.

// File: rtl/tws_pkg.sv
`timescale 1ns/1ps
package tws_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned STRAP_W    = 3;
  localparam logic [3:0]  DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_OFFER,
    ST_ACK,
    ST_FETCH,
    ST_SEND,
    ST_MACK,
    ST_NEXT
  } eng_state_e;
endpackage

// File: rtl/tws_in_filter.sv
`timescale 1ns/1ps
module tws_in_filter #(
  parameter int unsigned FILT_LEN = 3,
  parameter logic        INIT     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= {INIT, INIT};
      filt_o <= INIT;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == filt_o) begin
        run_q <= '0;
      end else if (run_q == LIMIT) begin
        filt_o <= sync_q[1];
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R9: the filtered level only ever moves to a level the synchronizer held
  a_r9_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_o != $past(filt_o)) |-> (filt_o == $past(sync_q[1])));
endmodule

// File: rtl/tws_cond_detect.sv
`timescale 1ns/1ps
module tws_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    start_p = scl_f & scl_q & sda_q & ~sda_f;
    stop_p  = scl_f & scl_q & ~sda_q & sda_f;
    rise_p  = scl_f & ~scl_q;
    fall_p  = ~scl_f & scl_q;
  end
endmodule

// File: rtl/tws_byte_engine.sv
`timescale 1ns/1ps
module tws_byte_engine
  import tws_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_p,
  input  logic               stop_p,
  input  logic               rise_p,
  input  logic               fall_p,
  input  logic               sda_f,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic               rx_ready_i,
  input  logic               tx_valid_i,
  input  logic [BYTE_W-1:0]  tx_data_i,
  output logic               start_o,
  output logic               stop_o,
  output logic               match_o,
  output logic               rw_o,
  output logic               rx_valid_o,
  output logic [BYTE_W-1:0]  rx_data_o,
  output logic               tx_ready_o,
  output logic               mack_valid_o,
  output logic               mack_nack_o,
  output logic               sda_oe_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

  eng_state_e        st;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              is_addr;
  logic              rd;
  logic              addr_hit;

  assign addr_hit = (shreg[BYTE_W-1:1] == {DEV_PREFIX, strap_i}) && !busy_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      shreg        <= '0;
      bitcnt       <= '0;
      is_addr      <= 1'b0;
      rd           <= 1'b0;
      sda_oe_o     <= 1'b0;
      start_o      <= 1'b0;
      stop_o       <= 1'b0;
      match_o      <= 1'b0;
      rw_o         <= 1'b0;
      rx_valid_o   <= 1'b0;
      rx_data_o    <= '0;
      tx_ready_o   <= 1'b0;
      mack_valid_o <= 1'b0;
      mack_nack_o  <= 1'b0;
    end else begin
      start_o      <= start_p;
      stop_o       <= stop_p;
      match_o      <= 1'b0;
      rx_valid_o   <= 1'b0;
      tx_ready_o   <= 1'b0;
      mack_valid_o <= 1'b0;
      if (start_p) begin
        st       <= ST_RECV;
        is_addr  <= 1'b1;
        rd       <= 1'b0;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_p) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (st)
          ST_RECV: begin
            if (rise_p) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_f};
              bitcnt <= bitcnt + 1'b1;
            end else if (fall_p && bitcnt == LAST_RX) begin
              bitcnt <= '0;
              if (is_addr) begin
                if (addr_hit) begin
                  match_o  <= 1'b1;
                  rw_o     <= shreg[0];
                  rd       <= shreg[0];
                  sda_oe_o <= 1'b1;
                  st       <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                rx_valid_o <= 1'b1;
                rx_data_o  <= shreg;
                st         <= ST_OFFER;
              end
            end
          end
          ST_OFFER: begin
            if (rx_ready_i) begin
              sda_oe_o <= 1'b1;
              st       <= ST_ACK;
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_ACK: begin
            if (fall_p) begin
              is_addr  <= 1'b0;
              sda_oe_o <= 1'b0;
              if (rd) begin
                tx_ready_o <= 1'b1;
                st         <= ST_FETCH;
              end else begin
                st <= ST_RECV;
              end
            end
          end
          ST_NEXT: begin
            if (fall_p) begin
              tx_ready_o <= 1'b1;
              st         <= ST_FETCH;
            end
          end
          ST_FETCH: begin
            shreg    <= tx_valid_i ? tx_data_i : '1;
            sda_oe_o <= tx_valid_i & ~tx_data_i[BYTE_W-1];
            bitcnt   <= '0;
            st       <= ST_SEND;
          end
          ST_SEND: begin
            if (fall_p) begin
              if (bitcnt == LAST_TX) begin
                sda_oe_o <= 1'b0;
                st       <= ST_MACK;
              end else begin
                shreg    <= {shreg[BYTE_W-2:0], 1'b1};
                sda_oe_o <= ~shreg[BYTE_W-2];
                bitcnt   <= bitcnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (rise_p) begin
              mack_valid_o <= 1'b1;
              mack_nack_o  <= sda_f;
              st           <= sda_f ? ST_IDLE : ST_NEXT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4: no select hit is reported when the write engine was busy
  a_r4_busy_blocks_match: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> !$past(busy_i));
  // R5: a refused byte is never acknowledged, an accepted one always is
  a_r5_refused_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> !sda_oe_o);
  a_r5_accepted_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && rx_ready_i) |=> sda_oe_o);
  // R6: first bit of a read byte follows the handshake
  a_r6_empty_sends_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready_o && !tx_valid_i) |=> !sda_oe_o);
  a_r6_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready_o && tx_valid_i) |=> (sda_oe_o == !$past(tx_data_i[BYTE_W-1])));
  // R7: a master NACK leaves the line released
  a_r7_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mack_valid_o && mack_nack_o) |-> !sda_oe_o);
  // R2: STOP leaves the line released
  a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> !sda_oe_o);
  // R10: strobes never coincide
  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o, match_o, rx_valid_o, tx_ready_o, mack_valid_o}));
endmodule

// File: rtl/tws_slave_front.sv
`timescale 1ns/1ps
module tws_slave_front
  import tws_pkg::*;
#(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  output logic               start_o,
  output logic               stop_o,
  output logic               match_o,
  output logic               rw_o,
  output logic               rx_valid_o,
  input  logic               rx_ready_i,
  output logic [BYTE_W-1:0]  rx_data_o,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  input  logic [BYTE_W-1:0]  tx_data_i,
  output logic               mack_valid_o,
  output logic               mack_nack_o
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] raw_w;
  logic [LINES-1:0] filt_w;
  logic start_p, stop_p, rise_p, fall_p;

  assign raw_w = {sda_i, scl_i};

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    tws_in_filter #(
      .FILT_LEN(FILT_LEN),
      .INIT    (1'b1)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_w[gi]),
      .filt_o(filt_w[gi])
    );
  end

  tws_cond_detect u_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_f  (filt_w[0]),
    .sda_f  (filt_w[1]),
    .start_p(start_p),
    .stop_p (stop_p),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  tws_byte_engine u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_p     (start_p),
    .stop_p      (stop_p),
    .rise_p      (rise_p),
    .fall_p      (fall_p),
    .sda_f       (filt_w[1]),
    .strap_i     (strap_i),
    .busy_i      (busy_i),
    .rx_ready_i  (rx_ready_i),
    .tx_valid_i  (tx_valid_i),
    .tx_data_i   (tx_data_i),
    .start_o     (start_o),
    .stop_o      (stop_o),
    .match_o     (match_o),
    .rw_o        (rw_o),
    .rx_valid_o  (rx_valid_o),
    .rx_data_o   (rx_data_o),
    .tx_ready_o  (tx_ready_o),
    .mack_valid_o(mack_valid_o),
    .mack_nack_o (mack_nack_o),
    .sda_oe_o    (sda_oe_o)
  );
endmodule

// File: tb/tws_slave_front_bench.sv
`timescale 1ns/1ps
module tws_slave_front_bench;
  localparam int FILT = 3;
  localparam int HALF = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       busy = 1'b0;
  logic       rx_ready = 1'b1;
  logic       tx_valid = 1'b1;
  logic [7:0] tx_data = 8'h00;

  logic       sda_oe, start_o, stop_o, match_o, rw_o, rx_valid_o, tx_ready_o;
  logic       mack_valid_o, mack_nack_o;
  logic [7:0] rx_data_o;
  logic       sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  tws_slave_front #(.FILT_LEN(FILT)) u_tws_slave_front (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(strap), .busy_i(busy), .start_o(start_o), .stop_o(stop_o),
    .match_o(match_o), .rw_o(rw_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready),
    .rx_data_o(rx_data_o), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready_o),
    .tx_data_i(tx_data), .mack_valid_o(mack_valid_o), .mack_nack_o(mack_nack_o));

  int total = 0;
  int bad = 0;
  int exp_q[$];
  int obs_q[$];
  logic may_drive = 1'b0;
  int grace = 0;
  int silence_bad = 0;
  logic m_sel = 1'b0;

  // strobe recorder and per-clock drive-window comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (start_o)      obs_q.push_back(1000);
      if (stop_o)       obs_q.push_back(2000);
      if (match_o)      obs_q.push_back(3000 + int'(rw_o));
      if (rx_valid_o)   obs_q.push_back(4000 + int'(rx_data_o));
      if (tx_ready_o)   obs_q.push_back(5000);
      if (mack_valid_o) obs_q.push_back(6000 + int'(mack_nack_o));
    end
    if (may_drive) grace = 0; else grace = grace + 1;
    if (!may_drive && grace > HALF && sda_oe) silence_bad = silence_bad + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic got);
    sda_m = b;
    wait_clk(HALF);
    scl_m = 1'b1;
    wait_clk(HALF / 2);
    got = sda_bus;
    wait_clk(HALF - HALF / 2);
    scl_m = 1'b0;
  endtask

  task automatic m_start();
    sda_m = 1'b1;
    wait_clk(HALF);
    scl_m = 1'b1;
    wait_clk(HALF);
    sda_m = 1'b0;
    wait_clk(HALF);
    scl_m = 1'b0;
    m_sel = 1'b0;
    exp_q.push_back(1000);
  endtask

  task automatic m_stop();
    sda_m = 1'b0;
    wait_clk(HALF);
    scl_m = 1'b1;
    wait_clk(HALF);
    sda_m = 1'b1;
    wait_clk(HALF);
    m_sel = 1'b0;
    exp_q.push_back(2000);
  endtask

  task automatic m_write(input logic [7:0] d, input bit is_addr, input string req);
    logic got;
    bit ok;
    for (int i = 7; i >= 0; i--) bit_xfer(d[i], got);
    if (is_addr) begin
      ok = (d[7:1] == {4'b1010, strap}) && !busy;
      m_sel = ok;
      if (ok) exp_q.push_back(3000 + int'(d[0]));
    end else if (m_sel) begin
      exp_q.push_back(4000 + int'(d));
      ok = rx_ready;
      m_sel = ok;
    end else begin
      ok = 1'b0;
    end
    may_drive = ok;
    bit_xfer(1'b1, got);
    may_drive = 1'b0;
    chk(got == !ok, req, int'(got), int'(!ok));
  endtask

  task automatic m_read(input logic last, input string req);
    logic got;
    logic [7:0] expb, byte_in;
    expb = tx_valid ? tx_data : 8'hFF;
    exp_q.push_back(5000);
    may_drive = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, got);
      byte_in[i] = got;
    end
    may_drive = 1'b0;
    chk(byte_in == expb, req, int'(byte_in), int'(expb));
    tx_data = tx_data + 8'h89;
    bit_xfer(last, got);
    exp_q.push_back(6000 + int'(last));
    if (last) m_sel = 1'b0;
  endtask

  task automatic check_events(input string req);
    int a, e, n;
    a = -1;
    e = -1;
    wait_clk(HALF);
    n = (exp_q.size() > obs_q.size()) ? exp_q.size() : obs_q.size();
    for (int i = 0; i < n; i++) begin
      int av, ev;
      av = (i < obs_q.size()) ? obs_q[i] : -1;
      ev = (i < exp_q.size()) ? exp_q[i] : -1;
      if (av != ev) begin
        a = av;
        e = ev;
        break;
      end
    end
    chk(a == e, req, a, e);
    exp_q.delete();
    obs_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic got;
    wait_clk(6);
    rst_n = 1'b1;
    wait_clk(20);
    // R10: quiet after reset
    chk(sda_oe == 1'b0, "R10 reset oe", int'(sda_oe), 0);
    check_events("R10 reset strobes");

    // R9: short SDA dip while SCL high is not a START
    sda_m = 1'b0;
    wait_clk(FILT - 1);
    sda_m = 1'b1;
    wait_clk(20);
    check_events("R9 sda glitch");

    // R1 R2 R3 R5: write two bytes to own select
    m_start();
    m_write(8'hAA, 1, "R3 select ack");
    m_write(8'h5C, 0, "R5 data ack 1");
    m_write(8'hA3, 0, "R5 data ack 2");
    m_stop();
    check_events("R1 R2 R5 write strobes");

    // R3: strap mismatch stays silent
    m_start();
    m_write(8'hA2, 1, "R3 miss nack");
    m_write(8'h11, 0, "R3 miss data ignored");
    m_stop();
    check_events("R3 miss strobes");

    // R4: busy blocks the select acknowledge
    busy = 1'b1;
    m_start();
    m_write(8'hAA, 1, "R4 busy nack");
    m_stop();
    busy = 1'b0;
    check_events("R4 busy strobes");

    // R5: refused byte gets NACK, next byte ignored
    rx_ready = 1'b0;
    m_start();
    m_write(8'hAA, 1, "R5 select ack");
    m_write(8'h77, 0, "R5 refused nack");
    m_write(8'h66, 0, "R5 after refusal");
    m_stop();
    rx_ready = 1'b1;
    check_events("R5 refusal strobes");

    // R6 R7 R8: random read with repeated START, ACK then NACK
    tx_data = 8'h3C;
    m_start();
    m_write(8'hAA, 1, "R8 select write");
    m_write(8'h34, 0, "R5 pointer byte");
    m_start();
    m_write(8'hAB, 1, "R3 select read");
    m_read(1'b0, "R6 read byte 1");
    m_read(1'b1, "R6 read byte 2");
    m_stop();
    check_events("R6 R7 read strobes");

    // R6: no data available sends all ones
    tx_valid = 1'b0;
    m_start();
    m_write(8'hAB, 1, "R3 select read 2");
    m_read(1'b1, "R6 empty byte");
    m_stop();
    tx_valid = 1'b1;
    check_events("R6 empty strobes");

    // R8: abort mid-byte then fresh select decode
    m_start();
    m_write(8'hAA, 1, "R8 first select");
    for (int i = 0; i < 4; i++) bit_xfer(1'b0, got);
    m_start();
    m_write(8'hAA, 1, "R8 reselect");
    m_write(8'h5A, 0, "R8 data after abort");
    m_stop();
    check_events("R8 abort strobes");

    // R9: SCL glitch in the low phase adds no bit
    m_start();
    m_write(8'hAA, 1, "R9 select");
    wait_clk(3);
    scl_m = 1'b1;
    wait_clk(FILT - 1);
    scl_m = 1'b0;
    m_write(8'hC3, 0, "R9 data ack");
    m_stop();
    check_events("R9 scl glitch strobes");

    chk(silence_bad == 0, "R10 drive window", silence_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule